// File: doc/BRIEF.md
# DMA Destination Address Generator

This block keeps the destination address of one DMA channel. Each completed transfer unit moves the address by a step. The step depends on a two-bit update mode and on the transfer size: byte, word or longword. The address can also be confined to a power-of-two repeat window. When the address runs past either edge of that window, it wraps to the other edge of the same window. The upper address bits are left unchanged.

A window overflow can be made to stop the channel. When it does, the block latches an interrupt-request flag and drops the active bit. In block transfer mode the stop waits for the end of the current block. Software can then set the active bit again, and the transfer carries on from the address held at the stop. Bus cycles, source addressing and arbitration are handled elsewhere.

Top module: `dma_dst_addr_gen`

## Requirements
- R1: After reset, `addr_o` is 0 and `active_o`, `irq_flag_o` and `irq_o` are all 0.
- R2: With `upd_mode_i` equal to 2'b00 or 2'b01, a transfer-done pulse leaves `addr_o` unchanged.
- R3: With `upd_mode_i` = 2'b10, each transfer-done pulse on an active channel adds the step to `addr_o` on the next clock. The step comes from `unit_i`: 0 gives 1, 1 gives 2, and 2 or 3 give 4.
- R4: With `upd_mode_i` = 2'b11, each transfer-done pulse subtracts the same step from `addr_o`.
- R5: While `ext_ack_dst_i` is 1, transfer-done pulses leave `addr_o` unchanged, whatever the update mode.
- R6: For `rpt_log2_i` = N in 1..15, an update that carries out of, or borrows out of, the low N address bits keeps the upper bits and takes only the low N bits of the result. When N = 0, the address moves over the full 32 bits.
- R7: If `rpt_ie_i` is 0, a window overflow wraps the address, the channel stays active and `irq_flag_o` stays 0.
- R8: If `rpt_ie_i` is 1 and `blk_mode_i` is 0, a window overflow has three effects on the next clock: `irq_flag_o` is set, `active_o` is cleared, and `addr_o` holds the wrapped value. While the channel is inactive, transfer-done pulses do not change the address.
- R9: If `blk_mode_i` is 1 and `rpt_ie_i` is 1, an overflow leaves the channel running. The flag is set and the channel is stopped on the clock after the next `blk_end_i` pulse.
- R10: `irq_o` is 1 exactly when `irq_flag_o` and `irq_en_i` are both 1.
- R11: Writing 1 to the active bit after an overflow stop resumes updates from the held address.
- R12: When `rpt_log2_i` is 0, `rpt_ie_i` has no effect: the channel is never stopped and the flag is never set.
- R13: A flag write with data 0 clears `irq_flag_o`. A flag write with data 1 leaves it unchanged.
- R14: Address writes are ignored while `active_o` is 1. They load `addr_o` on the next clock while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_wr_i | input | 1 | Address register write strobe |
| addr_wdata_i | input | 32 | Address write data |
| act_wr_i | input | 1 | Active bit write strobe |
| act_wdata_i | input | 1 | Active bit write data |
| flag_wr_i | input | 1 | Interrupt flag write strobe |
| flag_wdata_i | input | 1 | Flag write data (0 clears) |
| xfer_done_i | input | 1 | One transfer unit completed |
| blk_end_i | input | 1 | Current block completed |
| upd_mode_i | input | 2 | Update mode: 0x fixed, 10 increment, 11 decrement |
| unit_i | input | 2 | Transfer size: 0 byte, 1 word, 2/3 longword |
| rpt_log2_i | input | 4 | Repeat window is 2^N bytes, 0 means no window |
| rpt_ie_i | input | 1 | Stop on window overflow |
| irq_en_i | input | 1 | Channel interrupt enable |
| blk_mode_i | input | 1 | Block transfer mode |
| ext_ack_dst_i | input | 1 | Destination is an acknowledge-driven external device |
| addr_o | output | 32 | Current destination address |
| active_o | output | 1 | Channel active |
| irq_flag_o | output | 1 | Interrupt-request flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the deferred block-mode stop. It needs an overflow on one transfer, a further transfer inside the same block while the channel is still active, and only then a block-end pulse. The stimulus starts from an address just below the window edge and steps across it. It checks that the active bit survives the overflow and the following transfer, and that the stop comes only after the block end. A block end with no pending overflow is also sent, to show that it leaves the channel running.

// File: rtl/dma_dst_pkg.sv
package dma_dst_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned RPT_W  = 4;

  typedef enum logic [1:0] {
    UNIT_BYTE = 2'd0,
    UNIT_WORD = 2'd1,
    UNIT_LONG = 2'd2,
    UNIT_RSVD = 2'd3
  } unit_e;

  typedef enum logic [1:0] {
    DIR_HOLD,
    DIR_UP,
    DIR_DOWN
  } dir_e;

  function automatic dir_e decode_dir(logic [1:0] mode, logic ext_ack);
    if (ext_ack || !mode[1]) return DIR_HOLD;
    return mode[0] ? DIR_DOWN : DIR_UP;
  endfunction
endpackage

// File: rtl/dma_dst_step.sv
module dma_dst_step #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]     cur_i,
  input  logic [1:0]            unit_i,
  input  dma_dst_pkg::dir_e     dir_i,
  output logic [ADDR_W-1:0]     raw_o,
  output logic                  moving_o
);
  import dma_dst_pkg::*;

  logic [ADDR_W-1:0] step;

  always_comb begin
    unique case (unit_e'(unit_i))
      UNIT_BYTE: step = ADDR_W'(1);
      UNIT_WORD: step = ADDR_W'(2);
      default:   step = ADDR_W'(4);
    endcase
  end

  always_comb begin
    moving_o = 1'b1;
    unique case (dir_i)
      DIR_UP:   raw_o = cur_i + step;
      DIR_DOWN: raw_o = cur_i - step;
      default: begin
        raw_o    = cur_i;
        moving_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/dma_dst_wrap.sv
module dma_dst_wrap #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned RPT_W  = 4
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] raw_i,
  input  logic [RPT_W-1:0]  log2_i,
  output logic [ADDR_W-1:0] next_o,
  output logic              ovf_o
);
  localparam int unsigned IDX_W = $clog2(ADDR_W) + 1;

  logic [ADDR_W-1:0] low_sel;
  logic              win_on;

  assign win_on = |log2_i;

  // per bit: low bits follow the new value, upper bits stay put inside a window
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    assign low_sel[b] = !win_on || (IDX_W'(b) < IDX_W'(log2_i));
    assign next_o[b]  = low_sel[b] ? raw_i[b] : cur_i[b];
  end

  // carry/borrow out of the window shows as a change in the upper bits
  assign ovf_o = win_on && |((raw_i ^ cur_i) & ~low_sel);
endmodule

// File: rtl/dma_dst_ctrl.sv
module dma_dst_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_wr_i,
  input  logic act_wdata_i,
  input  logic flag_wr_i,
  input  logic flag_wdata_i,
  input  logic xfer_ok_i,
  input  logic ovf_i,
  input  logic blk_end_i,
  input  logic rpt_ie_i,
  input  logic blk_mode_i,
  output logic active_o,
  output logic flag_o
);
  logic active_q, flag_q, pend_q;
  logic ovf_hit, stop_now, stop_blk, stop;

  assign ovf_hit  = xfer_ok_i && ovf_i && rpt_ie_i;
  assign stop_now = ovf_hit && !blk_mode_i;
  assign stop_blk = active_q && blk_mode_i && blk_end_i && (pend_q || ovf_hit);
  assign stop     = stop_now || stop_blk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      flag_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (stop)          active_q <= 1'b0;
      else if (act_wr_i) active_q <= act_wdata_i;

      if (stop)                            flag_q <= 1'b1;
      else if (flag_wr_i && !flag_wdata_i) flag_q <= 1'b0;

      if (stop)                           pend_q <= 1'b0;
      else if (ovf_hit && blk_mode_i)     pend_q <= 1'b1;
    end
  end

  assign active_o = active_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/dma_dst_addr_gen.sv
module dma_dst_addr_gen #(
  parameter int unsigned ADDR_W = dma_dst_pkg::ADDR_W,
  parameter int unsigned RPT_W  = dma_dst_pkg::RPT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_wr_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  input  logic              act_wr_i,
  input  logic              act_wdata_i,
  input  logic              flag_wr_i,
  input  logic              flag_wdata_i,
  input  logic              xfer_done_i,
  input  logic              blk_end_i,
  input  logic [1:0]        upd_mode_i,
  input  logic [1:0]        unit_i,
  input  logic [RPT_W-1:0]  rpt_log2_i,
  input  logic              rpt_ie_i,
  input  logic              irq_en_i,
  input  logic              blk_mode_i,
  input  logic              ext_ack_dst_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              active_o,
  output logic              irq_flag_o,
  output logic              irq_o
);
  import dma_dst_pkg::*;

  logic [ADDR_W-1:0] addr_q, raw, next;
  logic              moving, ovf, xfer_ok;
  dir_e              dir;

  assign dir     = decode_dir(upd_mode_i, ext_ack_dst_i);
  assign xfer_ok = active_o && xfer_done_i;

  dma_dst_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_i   (addr_q),
    .unit_i  (unit_i),
    .dir_i   (dir),
    .raw_o   (raw),
    .moving_o(moving)
  );

  dma_dst_wrap #(.ADDR_W(ADDR_W), .RPT_W(RPT_W)) u_wrap (
    .cur_i (addr_q),
    .raw_i (raw),
    .log2_i(rpt_log2_i),
    .next_o(next),
    .ovf_o (ovf)
  );

  dma_dst_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_wr_i    (act_wr_i),
    .act_wdata_i (act_wdata_i),
    .flag_wr_i   (flag_wr_i),
    .flag_wdata_i(flag_wdata_i),
    .xfer_ok_i   (xfer_ok),
    .ovf_i       (ovf && moving),
    .blk_end_i   (blk_end_i),
    .rpt_ie_i    (rpt_ie_i),
    .blk_mode_i  (blk_mode_i),
    .active_o    (active_o),
    .flag_o      (irq_flag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    addr_q <= '0;
    else if (xfer_ok)               addr_q <= next;
    else if (!active_o && addr_wr_i) addr_q <= addr_wdata_i;
  end

  assign addr_o = addr_q;
  assign irq_o  = irq_flag_o && irq_en_i;
endmodule

// File: rtl/dma_dst_addr_gen_chk.sv
module dma_dst_addr_gen_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned RPT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_wr_i,
  input logic              flag_wr_i,
  input logic              flag_wdata_i,
  input logic              xfer_done_i,
  input logic [1:0]        upd_mode_i,
  input logic [RPT_W-1:0]  rpt_log2_i,
  input logic              blk_mode_i,
  input logic              ext_ack_dst_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              active_o,
  input logic              irq_flag_o,
  input logic              irq_o
);
  p_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && xfer_done_i && !upd_mode_i[1] |=> $stable(addr_o));

  p_ext_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && xfer_done_i && ext_ack_dst_i |=> $stable(addr_o));

  p_stop_clears_active_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_flag_o) |-> !active_o);

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o && !addr_wr_i |=> $stable(addr_o));

  p_irq_needs_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_flag_o);

  p_no_area_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && xfer_done_i && rpt_log2_i == '0 && !blk_mode_i |=> !$rose(irq_flag_o));

  p_flag_sticky_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_flag_o && !(flag_wr_i && !flag_wdata_i) |=> irq_flag_o);

  p_wr_ignored_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && addr_wr_i && !xfer_done_i |=> $stable(addr_o));
endmodule

bind dma_dst_addr_gen dma_dst_addr_gen_chk #(.ADDR_W(ADDR_W), .RPT_W(RPT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_wr_i    (addr_wr_i),
  .flag_wr_i    (flag_wr_i),
  .flag_wdata_i (flag_wdata_i),
  .xfer_done_i  (xfer_done_i),
  .upd_mode_i   (upd_mode_i),
  .rpt_log2_i   (rpt_log2_i),
  .blk_mode_i   (blk_mode_i),
  .ext_ack_dst_i(ext_ack_dst_i),
  .addr_o       (addr_o),
  .active_o     (active_o),
  .irq_flag_o   (irq_flag_o),
  .irq_o        (irq_o)
);

// File: tb/dma_dst_addr_gen_tb.sv
module dma_dst_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_wr = 0, act_wr = 0, act_wdata = 0, flag_wr = 0, flag_wdata = 0;
  logic [31:0] addr_wdata = '0;
  logic        xfer = 0, blk_end = 0;
  logic [1:0]  upd_mode = 0, unit_sz = 0;
  logic [3:0]  rpt_log2 = 0;
  logic        rpt_ie = 0, irq_en = 0, blk_mode = 0, ext_ack = 0;
  logic [31:0] addr;
  logic        active, irq_flag, irq;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  dma_dst_addr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .addr_wr_i(addr_wr), .addr_wdata_i(addr_wdata),
    .act_wr_i(act_wr), .act_wdata_i(act_wdata),
    .flag_wr_i(flag_wr), .flag_wdata_i(flag_wdata),
    .xfer_done_i(xfer), .blk_end_i(blk_end),
    .upd_mode_i(upd_mode), .unit_i(unit_sz), .rpt_log2_i(rpt_log2),
    .rpt_ie_i(rpt_ie), .irq_en_i(irq_en), .blk_mode_i(blk_mode),
    .ext_ack_dst_i(ext_ack),
    .addr_o(addr), .active_o(active), .irq_flag_o(irq_flag), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_active(logic v);
    act_wr = 1; act_wdata = v; tick(); act_wr = 0;
  endtask

  task automatic load_addr(logic [31:0] a);
    addr_wr = 1; addr_wdata = a; tick(); addr_wr = 0;
  endtask

  task automatic pulse_xfer();
    xfer = 1; tick(); xfer = 0;
  endtask

  task automatic clear_flag();
    flag_wr = 1; flag_wdata = 0; tick(); flag_wr = 0;
  endtask

  task automatic start(logic [31:0] a);
    set_active(0); clear_flag(); load_addr(a); set_active(1);
  endtask

  task automatic t_reset();
    chk("R1 addr", addr, 32'h0);
    chk("R1 active", {31'b0, active}, 32'h0);
    chk("R1 flag", {31'b0, irq_flag}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_fixed();
    rpt_log2 = 0; upd_mode = 2'b01; unit_sz = 2;
    start(32'h100);
    pulse_xfer();
    chk("R2 mode01", addr, 32'h100);
    upd_mode = 2'b00; pulse_xfer();
    chk("R2 mode00", addr, 32'h100);
  endtask

  task automatic t_inc_dec();
    upd_mode = 2'b10;
    unit_sz = 0; pulse_xfer(); chk("R3 byte", addr, 32'h101);
    unit_sz = 1; pulse_xfer(); chk("R3 word", addr, 32'h103);
    unit_sz = 2; pulse_xfer(); chk("R3 long", addr, 32'h107);
    unit_sz = 3; pulse_xfer(); chk("R3 code3", addr, 32'h10B);
    upd_mode = 2'b11;
    unit_sz = 2; pulse_xfer(); chk("R4 long", addr, 32'h107);
    unit_sz = 1; pulse_xfer(); chk("R4 word", addr, 32'h105);
    unit_sz = 0; pulse_xfer(); chk("R4 byte", addr, 32'h104);
  endtask

  task automatic t_ext();
    ext_ack = 1; upd_mode = 2'b10; pulse_xfer();
    chk("R5 ext inc", addr, 32'h104);
    upd_mode = 2'b11; pulse_xfer();
    chk("R5 ext dec", addr, 32'h104);
    ext_ack = 0;
  endtask

  task automatic t_wrap();
    rpt_log2 = 4; rpt_ie = 0; upd_mode = 2'b10; unit_sz = 2;
    start(32'h2000_001C);
    pulse_xfer();
    chk("R6 wrap up", addr, 32'h2000_0010);
    chk("R7 active", {31'b0, active}, 32'h1);
    chk("R7 flag", {31'b0, irq_flag}, 32'h0);
    upd_mode = 2'b11; unit_sz = 0; pulse_xfer();
    chk("R6 wrap down", addr, 32'h2000_001F);
    rpt_log2 = 0; rpt_ie = 1; upd_mode = 2'b10; unit_sz = 2;
    start(32'h2000_001C);
    pulse_xfer();
    chk("R6 no window", addr, 32'h2000_0020);
    chk("R12 active", {31'b0, active}, 32'h1);
    chk("R12 flag", {31'b0, irq_flag}, 32'h0);
  endtask

  task automatic t_stop();
    rpt_log2 = 3; rpt_ie = 1; irq_en = 1; blk_mode = 0; upd_mode = 2'b10; unit_sz = 1;
    start(32'h46);
    pulse_xfer();
    chk("R8 addr", addr, 32'h40);
    chk("R8 flag", {31'b0, irq_flag}, 32'h1);
    chk("R8 active", {31'b0, active}, 32'h0);
    chk("R10 irq on", {31'b0, irq}, 32'h1);
    pulse_xfer();
    chk("R8 idle xfer", addr, 32'h40);
    irq_en = 0; #1;
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    flag_wr = 1; flag_wdata = 1; tick(); flag_wr = 0;
    chk("R13 write1", {31'b0, irq_flag}, 32'h1);
    set_active(1);
    pulse_xfer();
    chk("R11 resume", addr, 32'h42);
    clear_flag();
    chk("R13 write0", {31'b0, irq_flag}, 32'h0);
    load_addr(32'hDEAD_0000);
    chk("R14 ignored", addr, 32'h42);
    set_active(0);
    load_addr(32'h0000_0050);
    chk("R14 loaded", addr, 32'h50);
  endtask

  task automatic t_block();
    rpt_log2 = 3; rpt_ie = 1; irq_en = 1; blk_mode = 1; upd_mode = 2'b10; unit_sz = 1;
    start(32'h44);
    blk_end = 1; tick(); blk_end = 0;
    chk("R9 idle blk end", {31'b0, active}, 32'h1);
    pulse_xfer(); pulse_xfer();
    chk("R9 wrapped", addr, 32'h40);
    chk("R9 still active", {31'b0, active}, 32'h1);
    chk("R9 no flag yet", {31'b0, irq_flag}, 32'h0);
    pulse_xfer();
    chk("R9 continues", addr, 32'h42);
    blk_end = 1; tick(); blk_end = 0;
    chk("R9 flag at end", {31'b0, irq_flag}, 32'h1);
    chk("R9 stopped", {31'b0, active}, 32'h0);
    blk_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_fixed();
    t_inc_dec();
    t_ext();
    t_wrap();
    t_stop();
    t_block();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule